// File: doc/BRIEF.md
# ISI-Shaping Unit-Element Selector

This block sits between an oversampled noise-shaping modulator and a bank of identical unit DAC segments. Every clock it receives a requested level `code_i` from 0 to NUM_SEG. It returns a NUM_SEG-bit enable vector with exactly that many bits set. Which segments carry the level decides how static mismatch and switching asymmetry turn into output error.

Three selection schemes are available through `mode_i`.

- **Rotation.** A circular pointer picks a contiguous run of segments and then advances by the code.
- **Mismatch shaping.** Each segment has a first-order usage integrator. A vector quantizer picks the segments that are most owed use.
- **ISI shaping.** A second first-order loop per segment integrates the segment's rising edges against a target rate of one quarter. That loop steers the choice toward keeping a constant, signal-independent transition density.

A per-segment dither field can be added to the priorities to break up idle patterns. NUM_SEG must be a power of two.

Top module: `isi_seg_select`

## Requirements
- R1: One clock after a code c (0..NUM_SEG) is presented, `seg_en_o` has exactly c bits set, in every mode.
- R2: A code above NUM_SEG is treated as NUM_SEG, so all segments are enabled one clock later.
- R3: While `rst_ni` is low, `seg_en_o` is all zero. Reset clears every integrator, the rotation pointer and the previous-state register.
- R4: Mode 2'b00 is rotation. Code c enables the c segments starting at the pointer and counting upward, modulo NUM_SEG. The pointer then advances by c modulo NUM_SEG and starts at 0 after reset.
- R5: In the shaping modes, the segments with the highest priority are enabled. Among equal priorities, lower segment indices win.
- R6: Mode 2'b01 is mismatch shaping. Priority is the segment's usage integrator plus dither. The integrator adds c/NUM_SEG each clock, loses 1 when the segment is enabled, and is clamped to ±SAT_INT. From reset, a constant code of NUM_SEG/2 therefore alternates between the lower and upper halves.
- R7: Modes 2'b10 and 2'b11 are ISI shaping. The priority gains +I for a segment that was off and −I for a segment that was on, where I is the segment's ISI integrator. I adds 1/4 each clock, loses 1 on an off-to-on change, and is clamped to ±SAT_INT. For a constant mid-scale code, the long-run rising-edge rate per segment is 0.25 ± 0.07.
- R8: `dither_i[i*DITH_W +: DITH_W]` is a signed value added to the priority of segment i, with one LSB equal to 1/NUM_SEG of a unit. It is ignored in rotation mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | CODE_W (6) | Requested number of enabled segments |
| dither_i | input | NUM_SEG*DITH_W (128) | Per-segment signed priority dither |
| mode_i | input | 2 | 00 rotation, 01 mismatch shaping, 10/11 ISI shaping |
| seg_en_o | output | NUM_SEG (32) | Registered segment-enable vector |

## Verification
Rotation is tried with codes that wrap past the top segment, with a full code and with an oversize code. The enable vector then reveals the pointer arithmetic and the clamp. Mismatch shaping is started from reset with half-scale and quarter-scale codes. This separates correct integrator update and lowest-index tie breaking from a plain rotation. Single-segment dither, positive and negative, shows that the dither field reaches the right segment. The ISI modes are run with a constant half-scale code. Their third selection, which keeps the same half enabled, and their long-run rising-edge rate of about 0.25 set them apart from the 0.5 rate of mismatch shaping.

// File: rtl/isi_sel_pkg.sv
package isi_sel_pkg;
  typedef enum logic [1:0] {
    MODE_DWA     = 2'd0,
    MODE_MSH     = 2'd1,
    MODE_ISI     = 2'd2,
    MODE_ISI_ALT = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/isi_seg_loop.sv
// Per-segment mismatch and ISI integrators, priority output.
module isi_seg_loop #(
  parameter int NUM_SEG = 32,
  parameter int CODE_W  = 6,
  parameter int FRAC_W  = 5,
  parameter int SAT_INT = 8,
  parameter int DITH_W  = 4,
  parameter int ACC_W   = 10,
  parameter int PRIO_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              sel_i,
  input  logic              prev_i,
  input  logic              isi_en_i,
  input  logic [DITH_W-1:0] dith_i,
  output logic [PRIO_W-1:0] prio_o,
  output logic [ACC_W-1:0]  mm_o,
  output logic [ACC_W-1:0]  isi_o
);
  localparam int ONE  = 1 << FRAC_W;
  localparam int LIM  = SAT_INT * ONE;
  localparam int RATE = ONE / 4;

  logic signed [ACC_W-1:0] mm_q, isi_q, mm_d, isi_d;
  int mm_nx, isi_nx, term, prio;

  always_comb begin
    mm_nx  = int'(mm_q) + (int'(code_i) * ONE) / NUM_SEG - (sel_i ? ONE : 0);
    isi_nx = int'(isi_q) + RATE - ((sel_i && !prev_i) ? ONE : 0);
    if (mm_nx > LIM) mm_nx = LIM;
    else if (mm_nx < -LIM) mm_nx = -LIM;
    if (isi_nx > LIM) isi_nx = LIM;
    else if (isi_nx < -LIM) isi_nx = -LIM;
    mm_d  = ACC_W'(mm_nx);
    isi_d = ACC_W'(isi_nx);
    // sign of the ISI term follows the segment's current state
    term   = isi_en_i ? (prev_i ? -int'(isi_q) : int'(isi_q)) : 0;
    prio   = int'(mm_q) + term + int'($signed(dith_i));
    prio_o = PRIO_W'(prio);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mm_q  <= '0;
      isi_q <= '0;
    end else begin
      mm_q  <= mm_d;
      isi_q <= isi_d;
    end
  end

  assign mm_o  = mm_q;
  assign isi_o = isi_q;
endmodule

// File: rtl/isi_vq.sv
// Vector quantizer: enable the code_i highest-priority segments.
module isi_vq #(
  parameter int NUM_SEG = 32,
  parameter int CODE_W  = 6,
  parameter int PRIO_W  = 12
) (
  input  logic [NUM_SEG-1:0][PRIO_W-1:0] prio_i,
  input  logic [CODE_W-1:0]              code_i,
  output logic [NUM_SEG-1:0]             sel_o
);
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_rank
    logic [CODE_W-1:0] rank;
    logic              sel_l;
    always_comb begin
      rank = '0;
      for (int j = 0; j < NUM_SEG; j++) begin
        if (j != i) begin
          if (($signed(prio_i[j]) > $signed(prio_i[i])) ||
              ((prio_i[j] == prio_i[i]) && (j < i)))
            rank = rank + CODE_W'(1);
        end
      end
      sel_l = rank < code_i;
    end
    assign sel_o[i] = sel_l;
  end
endmodule

// File: rtl/isi_dwa_ptr.sv
// Rotating pointer selection.
module isi_dwa_ptr #(
  parameter int NUM_SEG = 32,
  parameter int CODE_W  = 6,
  parameter int PTR_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic [NUM_SEG-1:0] sel_o
);
  logic [PTR_W-1:0] ptr_q;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_win
    logic [PTR_W-1:0] off;
    assign off      = PTR_W'(i) - ptr_q;
    assign sel_o[i] = CODE_W'(off) < code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_q + PTR_W'(code_i);
  end
endmodule

// File: rtl/isi_seg_select.sv
module isi_seg_select
  import isi_sel_pkg::*;
#(
  parameter int NUM_SEG = 32,
  parameter int DITH_W  = 4,
  parameter int SAT_INT = 8,
  localparam int CODE_W = $clog2(NUM_SEG + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CODE_W-1:0]         code_i,
  input  logic [NUM_SEG*DITH_W-1:0] dither_i,
  input  logic [1:0]                mode_i,
  output logic [NUM_SEG-1:0]        seg_en_o
);
  localparam int PTR_W  = $clog2(NUM_SEG);
  localparam int FRAC_W = PTR_W;
  localparam int ONE    = 1 << FRAC_W;
  localparam int LIM    = SAT_INT * ONE;
  localparam int ACC_W  = $clog2(LIM + ONE + 1) + 1;
  localparam int PRIO_W = ACC_W + 2;

  sel_mode_e          mode;
  logic               dwa_mode, isi_en;
  logic [CODE_W-1:0]  code_sat;
  logic [NUM_SEG-1:0] sel_vq, sel_dwa, sel_nx, seg_q;
  logic [NUM_SEG-1:0][PRIO_W-1:0] prio;
  logic [NUM_SEG-1:0][ACC_W-1:0]  mm_all, isi_all;

  assign mode     = sel_mode_e'(mode_i);
  assign dwa_mode = (mode == MODE_DWA);
  assign isi_en   = (mode == MODE_ISI) || (mode == MODE_ISI_ALT);
  assign code_sat = (code_i > CODE_W'(NUM_SEG)) ? CODE_W'(NUM_SEG) : code_i;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    isi_seg_loop #(
      .NUM_SEG(NUM_SEG), .CODE_W(CODE_W), .FRAC_W(FRAC_W), .SAT_INT(SAT_INT),
      .DITH_W(DITH_W), .ACC_W(ACC_W), .PRIO_W(PRIO_W)
    ) u_loop (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .code_i  (code_sat),
      .sel_i   (sel_nx[i]),
      .prev_i  (seg_q[i]),
      .isi_en_i(isi_en),
      .dith_i  (dither_i[i*DITH_W +: DITH_W]),
      .prio_o  (prio[i]),
      .mm_o    (mm_all[i]),
      .isi_o   (isi_all[i])
    );
  end

  isi_vq #(.NUM_SEG(NUM_SEG), .CODE_W(CODE_W), .PRIO_W(PRIO_W)) u_vq (
    .prio_i(prio),
    .code_i(code_sat),
    .sel_o (sel_vq)
  );

  isi_dwa_ptr #(.NUM_SEG(NUM_SEG), .CODE_W(CODE_W), .PTR_W(PTR_W)) u_dwa (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (dwa_mode),
    .code_i(code_sat),
    .sel_o (sel_dwa)
  );

  assign sel_nx = dwa_mode ? sel_dwa : sel_vq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_q <= '0;
    else         seg_q <= sel_nx;
  end

  assign seg_en_o = seg_q;
endmodule

// File: rtl/isi_seg_select_chk.sv
module isi_seg_select_chk #(
  parameter int NUM_SEG = 32,
  parameter int CODE_W  = 6,
  parameter int ACC_W   = 10,
  parameter int LIM     = 256
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [CODE_W-1:0]              code_i,
  input logic [1:0]                     mode_i,
  input logic [NUM_SEG-1:0]             seg_en_o,
  input logic [NUM_SEG-1:0][ACC_W-1:0]  mm_all,
  input logic [NUM_SEG-1:0][ACC_W-1:0]  isi_all
);
  logic               v_q;
  logic [NUM_SEG-1:0] seg_rot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= 1'b0;
    else         v_q <= 1'b1;
  end

  assign seg_rot = {seg_en_o[NUM_SEG-2:0], seg_en_o[NUM_SEG-1]};

  AST_POPCOUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && ($past(code_i) <= CODE_W'(NUM_SEG)) |->
      $countones(seg_en_o) == int'($past(code_i))); // R1

  AST_CLAMP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && ($past(code_i) > CODE_W'(NUM_SEG)) |-> (&seg_en_o)); // R2

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_q |-> (seg_en_o == '0)); // R3

  AST_DWA_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && ($past(mode_i) == 2'd0) && ($past(code_i) != '0) &&
    ($past(code_i) < CODE_W'(NUM_SEG)) |->
      $countones(seg_en_o & ~seg_rot) == 1); // R4

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_bound
    AST_MM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'($signed(mm_all[i])) <= LIM) && (int'($signed(mm_all[i])) >= -LIM)); // R6
    AST_ISI_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'($signed(isi_all[i])) <= LIM) && (int'($signed(isi_all[i])) >= -LIM)); // R7
  end
endmodule

bind isi_seg_select isi_seg_select_chk #(
  .NUM_SEG(NUM_SEG), .CODE_W(CODE_W), .ACC_W(ACC_W), .LIM(LIM)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .code_i  (code_i),
  .mode_i  (mode_i),
  .seg_en_o(seg_en_o),
  .mm_all  (mm_all),
  .isi_all (isi_all)
);

// File: tb/isi_seg_select_tb_top.sv
module isi_seg_select_tb_top;
  localparam int NS = 32;
  localparam int DW = 4;
  localparam int CW = 6;

  typedef struct packed {
    logic          rst;
    logic [1:0]    mode;
    logic [CW-1:0] code;
    logic [4:0]    dseg;
    logic [DW-1:0] dval;
    logic [NS-1:0] expv;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // rotation: R4 pointer walk, R2 clamp
    '{1'b1, 2'd0, 6'd5,  5'd0, 4'h0, 32'h0000001F, 4'd4},
    '{1'b0, 2'd0, 6'd3,  5'd0, 4'h0, 32'h000000E0, 4'd4},
    '{1'b0, 2'd0, 6'd30, 5'd0, 4'h0, 32'hFFFFFF3F, 4'd4},
    '{1'b0, 2'd0, 6'd32, 5'd0, 4'h0, 32'hFFFFFFFF, 4'd4},
    '{1'b0, 2'd0, 6'd2,  5'd0, 4'h0, 32'h000000C0, 4'd4},
    '{1'b0, 2'd0, 6'd63, 5'd0, 4'h0, 32'hFFFFFFFF, 4'd2},
    '{1'b0, 2'd0, 6'd0,  5'd0, 4'h0, 32'h00000000, 4'd1},
    '{1'b0, 2'd0, 6'd1,  5'd0, 4'h0, 32'h00000100, 4'd4},
    // mismatch shaping: R5 ties, R6 integrator, R8 dither
    '{1'b1, 2'd1, 6'd16, 5'd0, 4'h0, 32'h0000FFFF, 4'd5},
    '{1'b0, 2'd1, 6'd16, 5'd0, 4'h0, 32'hFFFF0000, 4'd6},
    '{1'b0, 2'd1, 6'd16, 5'd0, 4'h0, 32'h0000FFFF, 4'd6},
    '{1'b0, 2'd1, 6'd8,  5'd0, 4'h0, 32'h00FF0000, 4'd6},
    '{1'b0, 2'd1, 6'd8,  5'd0, 4'h0, 32'hFF000000, 4'd6},
    '{1'b0, 2'd1, 6'd0,  5'd0, 4'h0, 32'h00000000, 4'd1},
    '{1'b0, 2'd1, 6'd40, 5'd0, 4'h0, 32'hFFFFFFFF, 4'd2},
    '{1'b0, 2'd1, 6'd1,  5'd5, 4'h1, 32'h00000020, 4'd8},
    '{1'b0, 2'd1, 6'd1,  5'd0, 4'hF, 32'h00000002, 4'd8},
    // ISI shaping: R7 keeps the same half on in the third cycle
    '{1'b1, 2'd2, 6'd16, 5'd0, 4'h0, 32'h0000FFFF, 4'd5},
    '{1'b0, 2'd2, 6'd16, 5'd0, 4'h0, 32'hFFFF0000, 4'd7},
    '{1'b0, 2'd2, 6'd16, 5'd0, 4'h0, 32'hFFFF0000, 4'd7},
    '{1'b1, 2'd3, 6'd16, 5'd0, 4'h0, 32'h0000FFFF, 4'd5},
    '{1'b0, 2'd3, 6'd16, 5'd0, 4'h0, 32'hFFFF0000, 4'd7},
    '{1'b0, 2'd3, 6'd16, 5'd0, 4'h0, 32'hFFFF0000, 4'd7}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] code = '0;
  logic [NS*DW-1:0] dith = '0;
  logic [1:0]    mode = 2'd0;
  logic [NS-1:0] seg;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  isi_seg_select dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .code_i  (code),
    .dither_i(dith),
    .mode_i  (mode),
    .seg_en_o(seg)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic check_vec(string req, logic [NS-1:0] act, logic [NS-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: seg_en %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_ok(string req, bit ok, string got, string want);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %s expected %s", req, got, want);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    code  = '0;
    dith  = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rate_run(input logic [1:0] m, output real rate, output int pc_bad);
    logic [NS-1:0] prev;
    int rises;
    do_reset();
    mode   = m;
    code   = CW'(16);
    prev   = '0;
    rises  = 0;
    pc_bad = 0;
    for (int k = 0; k < 2500; k++) begin
      @(negedge clk);
      if ($countones(seg) != 16) pc_bad++;
      if (k >= 500) rises += $countones(seg & ~prev);
      prev = seg;
    end
    rate = real'(rises) / (2000.0 * NS);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, R1 to R8 unfinished");
    summary();
    $finish;
  end

  initial begin
    real r;
    int  pcb;
    // R3: outputs stay off while reset is held with active inputs
    @(negedge clk);
    mode = 2'd0;
    code = CW'(20);
    repeat (3) @(negedge clk);
    check_vec("R3 during reset", seg, '0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].rst) begin
        do_reset();
        check_vec("R3 after reset", seg, '0);
      end
      mode = VECS[v].mode;
      code = VECS[v].code;
      dith = '0;
      dith[int'(VECS[v].dseg)*DW +: DW] = VECS[v].dval;
      @(negedge clk);
      check_vec($sformatf("R%0d vector %0d", VECS[v].rq, v), seg, VECS[v].expv);
    end

    // R7: ISI shaping rate near 0.25
    rate_run(2'd2, r, pcb);
    check_ok("R1 popcount in ISI run", pcb == 0, $sformatf("%0d bad", pcb), "0 bad");
    check_ok("R7 ISI rise rate", (r > 0.18) && (r < 0.32),
             $sformatf("%f", r), "0.25 +/- 0.07");
    rate_run(2'd3, r, pcb);
    check_ok("R7 alt ISI rise rate", (r > 0.18) && (r < 0.32) && (pcb == 0),
             $sformatf("%f/%0d", r, pcb), "0.25 +/- 0.07/0");
    // R6: pure mismatch shaping alternates halves, rate 0.5
    rate_run(2'd1, r, pcb);
    check_ok("R6 mismatch rise rate", (r > 0.45) && (pcb == 0),
             $sformatf("%f/%0d", r, pcb), "0.5/0");

    summary();
    $finish;
  end
endmodule